// File: doc/BRIEF.md
# Brownout Chip-Enable Gate

This block sits between a processor's memory chip-enable strobe (active low) and a battery-backed RAM. While the supply is valid, the strobe passes through to the RAM unchanged, one clock later. When the supply becomes invalid, the strobe is blocked so that the RAM cannot be written. A new access never gets through while the supply is invalid.

An access that is already in progress at the moment the supply fails is allowed to finish. It keeps its enable for a bounded grace window. The window ends early if the strobe rises. The window length is a cycle count derived from the clock frequency and a duration in microseconds. Battery-backup mode overrides everything and holds the output inactive. After the window, the output stays high until the supply is valid again. From then on the strobe is sampled afresh.

Top module: `brownout_ce_gate`

## Requirements
- R1: While `rst` is high, `ce_out_n` is 1. At the first edge with `rst` low, `ce_out_n` takes the value of `ce_in_n` if the supply is valid (`supply_ok`=1 and `on_battery`=0).
- R2: At every clock edge where the supply is valid, `ce_out_n` becomes the value `ce_in_n` had at that edge (a one-cycle registered replica).
- R3: At an edge where the supply is invalid and `ce_in_n` is 1, `ce_out_n` becomes 1.
- R4: Let edge k be the first edge with the supply invalid while both `ce_in_n` and `ce_out_n` are 0. If `ce_in_n` stays 0, `ce_out_n` stays 0 after edges k through k+G-1 and becomes 1 at edge k+G, where G = CLK_MHZ*GRACE_US.
- R5: During the grace window, `ce_out_n` becomes 1 at the first edge that samples `ce_in_n` as 1.
- R6: If `ce_out_n` is 1 while the supply is invalid, it stays 1 whatever `ce_in_n` does. This includes an input that falls in the same cycle the supply fails.
- R7: At any edge where `on_battery` is 1, `ce_out_n` becomes 1, even inside a grace window.
- R8: Once the grace window has closed, `ce_out_n` stays 1 until an edge that samples the supply valid. At that edge it follows `ce_in_n` again.
- R9: If the supply returns to valid during a grace window, `ce_out_n` follows `ce_in_n` from that edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that also times the grace window |
| rst | input | 1 | Synchronous active-high reset |
| supply_ok | input | 1 | 1 when the supply is above the reset threshold |
| on_battery | input | 1 | 1 when the RAM is running from the backup battery |
| ce_in_n | input | 1 | Chip-enable strobe from the processor, active low |
| ce_out_n | output | 1 | Gated chip enable to the RAM, active low, registered |

## Verification
Every result is due one edge after the inputs it depends on: `ce_out_n` is the only register on the path. The bench therefore changes inputs shortly after an edge and samples just after the next edge. The grace window is swept by raising the strobe at each offset from 0 to beyond G. At each offset the expected level is computed as low only while the edge index is below both G and the rise offset. Battery entry and supply recovery are injected at chosen offsets inside the window, and their effect is expected at that same edge.

// File: rtl/ceg_pkg.sv
package ceg_pkg;
  typedef enum logic [1:0] {
    GATE_BLOCK = 2'd0,
    GATE_PASS  = 2'd1,
    GATE_HOLD  = 2'd2
  } gate_state_t;
endpackage

// File: rtl/ceg_grace_timer.sv
module ceg_grace_timer #(
  parameter int GRACE_CYCLES = 3000,
  localparam int CNT_W = $clog2(GRACE_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic run,
  output logic done
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(GRACE_CYCLES);
  logic [CNT_W-1:0] cnt_q;

  // start loads 1 (the entry edge counts as the first grace cycle)
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (start) begin
      cnt_q <= CNT_W'(1);
    end else if (run && (cnt_q != LAST)) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign done = (cnt_q == LAST);
endmodule

// File: rtl/ceg_gate_fsm.sv
module ceg_gate_fsm
  import ceg_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic valid,
  input  logic batt,
  input  logic ce_in_n,
  input  logic out_q,
  input  logic timer_done,
  output logic timer_start,
  output logic timer_run,
  output logic out_next
);
  gate_state_t state_q, state_d;

  always_comb begin
    state_d     = state_q;
    timer_start = 1'b0;
    out_next    = 1'b1;
    if (valid) begin
      state_d  = GATE_PASS;
      out_next = ce_in_n;
    end else begin
      unique case (state_q)
        GATE_PASS: begin
          if (!batt && !ce_in_n && !out_q) begin
            state_d     = GATE_HOLD;
            timer_start = 1'b1;
            out_next    = 1'b0;
          end else begin
            state_d = GATE_BLOCK;
          end
        end
        GATE_HOLD: begin
          if (batt || ce_in_n || timer_done) begin
            state_d = GATE_BLOCK;
          end else begin
            out_next = 1'b0;
          end
        end
        default: state_d = GATE_BLOCK;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= GATE_BLOCK;
    else     state_q <= state_d;
  end

  assign timer_run = (state_q == GATE_HOLD);
endmodule

// File: rtl/brownout_ce_gate.sv
module brownout_ce_gate #(
  parameter int CLK_MHZ  = 200,
  parameter int GRACE_US = 15,
  localparam int GRACE_CYCLES = CLK_MHZ * GRACE_US
) (
  input  logic clk,
  input  logic rst,
  input  logic supply_ok,
  input  logic on_battery,
  input  logic ce_in_n,
  output logic ce_out_n
);
  logic valid, t_start, t_run, t_done, out_d, out_q;

  assign valid = supply_ok && !on_battery;

  ceg_grace_timer #(.GRACE_CYCLES(GRACE_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .start(t_start), .run(t_run), .done(t_done)
  );

  ceg_gate_fsm u_fsm (
    .clk(clk), .rst(rst), .valid(valid), .batt(on_battery),
    .ce_in_n(ce_in_n), .out_q(out_q), .timer_done(t_done),
    .timer_start(t_start), .timer_run(t_run), .out_next(out_d)
  );

  always_ff @(posedge clk) begin
    if (rst) out_q <= 1'b1;
    else     out_q <= out_d;
  end

  assign ce_out_n = out_q;
endmodule

// File: rtl/ceg_checker.sv
module ceg_checker #(
  parameter int GRACE_CYCLES = 3000
) (
  input logic clk,
  input logic rst,
  input logic supply_ok,
  input logic on_battery,
  input logic ce_in_n,
  input logic ce_out_n
);
  logic [31:0] low_run_q;

  always_ff @(posedge clk) begin
    if (rst) low_run_q <= '0;
    else if (!supply_ok && !ce_out_n) low_run_q <= low_run_q + 32'd1;
    else low_run_q <= '0;
  end

  assert_follow_R2: assert property (@(posedge clk) disable iff (rst)
    (supply_ok && !on_battery) |=> (ce_out_n == $past(ce_in_n)));

  assert_high_in_R3: assert property (@(posedge clk) disable iff (rst)
    ce_in_n |=> ce_out_n);

  assert_grace_bound_R4: assert property (@(posedge clk) disable iff (rst)
    low_run_q <= 32'(GRACE_CYCLES + 1));

  assert_no_new_access_R6: assert property (@(posedge clk) disable iff (rst)
    (!supply_ok && ce_out_n) |=> ce_out_n);

  assert_battery_R7: assert property (@(posedge clk) disable iff (rst)
    on_battery |=> ce_out_n);
endmodule

bind brownout_ce_gate ceg_checker #(.GRACE_CYCLES(GRACE_CYCLES)) u_ceg_checker (
  .clk(clk), .rst(rst), .supply_ok(supply_ok), .on_battery(on_battery),
  .ce_in_n(ce_in_n), .ce_out_n(ce_out_n)
);

// File: tb/brownout_ce_gate_bench.sv
`timescale 1ns/1ps
module brownout_ce_gate_bench;
  localparam int CLK_MHZ = 1;
  localparam int GRACE_US = 5;
  localparam int G = CLK_MHZ * GRACE_US;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic supply_ok = 1'b1;
  logic on_battery = 1'b0;
  logic ce_in_n = 1'b1;
  logic ce_out_n;
  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  brownout_ce_gate #(.CLK_MHZ(CLK_MHZ), .GRACE_US(GRACE_US)) u_brownout_ce_gate (
    .clk(clk), .rst(rst), .supply_ok(supply_ok), .on_battery(on_battery),
    .ce_in_n(ce_in_n), .ce_out_n(ce_out_n)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", req, act, exp, $time);
    end
  endtask

  // valid supply, access active (output low)
  task automatic settle_active();
    supply_ok = 1'b1; on_battery = 1'b0; ce_in_n = 1'b0;
    step(); step();
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected<=20000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    ce_in_n = 1'b0;
    step(); step();
    check("R1 reset", ce_out_n, 1'b1);
    rst = 1'b0;
    step();
    check("R1 release", ce_out_n, 1'b0);

    // R2 pass-through of a pattern
    for (int i = 0; i < 16; i++) begin
      logic v;
      v = logic'((i * 5 + (i >> 2)) & 1);
      ce_in_n = v;
      step();
      check("R2 follow", ce_out_n, v);
    end

    // R4 R5 R8 sweep of rise offset over the window
    for (int r = 1; r <= G + 2; r++) begin
      settle_active();
      supply_ok = 1'b0;
      for (int i = 0; i <= G + 2; i++) begin
        if (i == r) ce_in_n = 1'b1;
        step();
        check((r > G) ? "R4 window" : "R5 rise", ce_out_n,
              (i < G && i < r) ? 1'b0 : 1'b1);
      end
      ce_in_n = 1'b0;
      step(); step();
      check("R8 stays high", ce_out_n, 1'b1);
      supply_ok = 1'b1;
      step();
      check("R8 recover", ce_out_n, 1'b0);
    end

    // R3 R6 invalid with input high, later low
    supply_ok = 1'b1; ce_in_n = 1'b1; step();
    supply_ok = 1'b0; step();
    check("R3 high in", ce_out_n, 1'b1);
    ce_in_n = 1'b0; step(); step();
    check("R6 new access", ce_out_n, 1'b1);

    // R6 input falls in the cycle the supply fails
    supply_ok = 1'b1; ce_in_n = 1'b1; step();
    supply_ok = 1'b0; ce_in_n = 1'b0; step();
    check("R6 same cycle", ce_out_n, 1'b1);
    step();
    check("R6 same cycle later", ce_out_n, 1'b1);

    // R7 battery at each offset in the window
    for (int j = 0; j < G; j++) begin
      settle_active();
      supply_ok = 1'b0;
      for (int i = 0; i <= j; i++) begin
        if (i == j) on_battery = 1'b1;
        step();
        check("R7 battery", ce_out_n, (i == j) ? 1'b1 : 1'b0);
      end
      on_battery = 1'b0;
    end
    settle_active();
    on_battery = 1'b1; step();
    check("R7 battery valid supply", ce_out_n, 1'b1);
    on_battery = 1'b0;

    // R9 supply returns mid-window
    settle_active();
    supply_ok = 1'b0; step(); step();
    check("R9 in window", ce_out_n, 1'b0);
    supply_ok = 1'b1; ce_in_n = 1'b1; step();
    check("R9 follow high", ce_out_n, 1'b1);
    ce_in_n = 1'b0; step();
    check("R9 follow low", ce_out_n, 1'b0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule